// File: doc/BRIEF.md
# Match-Based Watchdog Reset Timer

This peripheral is a watchdog built around a compare-match counter. An up-counter advances once per clock while it is enabled. Each cycle its value is compared with a programmable match register. When the two are equal, the block carries out the actions selected in a match-action register on the next clock edge. Those actions are: set an interrupt flag, return the counter to zero and stop it, drive an external match pin, and start a reset pulse on either of two reset outputs. Software can also start either reset pulse directly. The pulse lasts for a programmable number of clocks plus a fixed overhead.

Software reaches eight 32-bit word registers through a plain register bus: byte address, write strobe, write data and a combinational read path. A debug-halt input can freeze the counter. A sticky reset-cause bit records that a watchdog reset pulse was issued. It lives in the power-on domain, together with the pulse generators, so that the system reset the pulse itself causes does not erase it.

Top module: `wdg_match_timer`

## Requirements
- R1: After reset every register reads zero, and `irq`, `match_pin`, `rst_out_a` and `rst_out_b` are low. Word offsets are: 0x00 interrupt flag, 0x04 control, 0x08 counter, 0x0C match actions, 0x10 match value, 0x14 pin control, 0x18 pulse length, 0x1C reset cause.
- R2: When control bit 0 is set, the counter rises by one on each clock edge. Writing zero to control stops it; the write edge itself still counts, and the value then holds.
- R3: A control write with bit 1 set returns the counter to zero on that write's edge. Bit 1 always reads back as 0.
- R4: When control bit 2 is set and `dbg_halt` is high, the counter holds. When bit 2 is clear, `dbg_halt` has no effect.
- R5: A match is the counter equalling the match value while it is counting. With action bit 0 set, a match sets interrupt bit 0 and `irq` on the next edge; the counter then reads match+1. Writing 1 to interrupt bit 0 clears it, and writing 0 leaves it set.
- R6: With action bit 2 set, a match returns the counter to zero and clears control bit 0 on the next edge.
- R7: Pin control bit 0 is the pin state and can be written. Field [5:4] selects the change made on a match: 0 none, 1 drive low, 2 drive high, 3 invert.
- R8: On a match, action bit 3 starts a pulse on `rst_out_a` and action bit 4 starts a pulse on `rst_out_b`. A pulse lasts (pulse length register + 6) clocks. The other output stays low.
- R9: Writing action bit 5 (or bit 6) raises `rst_out_a` (or `rst_out_b`) on the write edge, for the same length as in R8. These two bits are not stored and read as 0.
- R10: Cause bit 0 becomes 1 when any reset pulse starts. It survives `rst_n`, ignores writes, and is cleared only by `por_n`.
- R11: The counter register ignores bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| por_n | input | 1 | Power-on reset, active low; clears everything |
| rst_n | input | 1 | System reset, active low; spares the cause bit and the pulse generators |
| dbg_halt | input | 1 | Debugger halt request |
| addr | input | 5 | Byte address of the word accessed |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word |
| irq | output | 1 | Match interrupt flag |
| match_pin | output | 1 | External match pin |
| rst_out_a | output | 1 | First reset pulse output |
| rst_out_b | output | 1 | Second reset pulse output |

## Verification
The bench checks the counter value at the exact edge where each thing happens:
- A clear or a stop written while the counter runs. A design that resolved clear against increment in the wrong order would read 1 where 0 is expected.
- The edge after a match. An off-by-one comparator shows up as a counter of match+2, or, with the stop action, as a counter that is not zero.
- Each reset pulse, whose high clocks are counted. A generator whose load value was off by one would give 8 or 10 clocks instead of 9.
- The cause bit across a system reset, which it must survive.
- Every code of the pin field. A swapped code leaves the pin in the wrong level.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // word index = byte address [4:2]
   localparam logic [2:0] W_IRQ   = 3'd0;
   localparam logic [2:0] W_CTRL  = 3'd1;
   localparam logic [2:0] W_COUNT = 3'd2;
   localparam logic [2:0] W_ACT   = 3'd3;
   localparam logic [2:0] W_MATCH = 3'd4;
   localparam logic [2:0] W_PIN   = 3'd5;
   localparam logic [2:0] W_PLEN  = 3'd6;
   localparam logic [2:0] W_CAUSE = 3'd7;

   typedef enum logic [1:0] {
      PIN_KEEP = 2'd0,
      PIN_LOW  = 2'd1,
      PIN_HIGH = 2'd2,
      PIN_FLIP = 2'd3
   } pin_act_e;
endpackage

// File: rtl/wdg_count_core.sv
module wdg_count_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic             stop_clr,
   input  logic [CNT_W-1:0] match_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr || stop_clr)  cnt <= '0;
      else if (tick)             cnt <= cnt + ONE;
   end

   assign hit = tick && (cnt == match_val);

   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && !stop_clr) |=> (cnt == $past(cnt) + ONE));
   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr && !stop_clr) |=> $stable(cnt));
endmodule

// File: rtl/wdg_pin_ctl.sv
module wdg_pin_ctl
   import wdg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr,
   input  logic     wr_pin,
   input  pin_act_e wr_act,
   input  logic     evt,
   output logic     pin,
   output pin_act_e act
);
   logic pin_nxt;

   always_comb begin
      unique case (act)
         PIN_LOW:  pin_nxt = 1'b0;
         PIN_HIGH: pin_nxt = 1'b1;
         PIN_FLIP: pin_nxt = ~pin;
         default:  pin_nxt = pin;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin <= 1'b0;
         act <= PIN_KEEP;
      end else if (wr) begin
         pin <= wr_pin;
         act <= wr_act;
      end else if (evt) begin
         pin <= pin_nxt;
      end
   end

   assert_pin_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !wr && act == PIN_HIGH) |=> pin);
   assert_pin_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !wr && act == PIN_FLIP) |=> (pin != $past(pin)));
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
   parameter int unsigned LEN_W = 16,
   parameter int unsigned EXTRA = 6
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             trig,
   input  logic [LEN_W-1:0] len,
   output logic             active
);
   localparam int unsigned REM_W = LEN_W + 1;
   localparam logic [REM_W-1:0] EXTRA_M1 = REM_W'(EXTRA - 1);

   logic [REM_W-1:0] rem;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         active <= 1'b0;
         rem    <= '0;
      end else if (!active) begin
         if (trig) begin
            active <= 1'b1;
            rem    <= REM_W'(len) + EXTRA_M1;
         end
      end else if (rem == '0) begin
         active <= 1'b0;
      end else begin
         rem <= rem - REM_W'(1);
      end
   end

   assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!por_n)
      (trig && !active) |=> active);
   assert_pulse_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
      (active && rem != '0) |=> active);
endmodule

// File: rtl/wdg_match_timer.sv
module wdg_match_timer
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned PULSE_W     = 16,
   parameter int unsigned PULSE_EXTRA = 6
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        rst_n,
   input  logic        dbg_halt,
   input  logic [4:0]  addr,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq,
   output logic        match_pin,
   output logic        rst_out_a,
   output logic        rst_out_b
);
   localparam int unsigned N_RST = 2;

   if (CNT_W < 16 || CNT_W > 32) begin : g_bad_cnt_w
      $error("CNT_W must lie in 16..32");
   end
   if (PULSE_W < 2 || PULSE_W > CNT_W) begin : g_bad_pulse_w
      $error("PULSE_W must lie in 2..CNT_W");
   end
   if (PULSE_EXTRA < 1 || PULSE_EXTRA >= (1 << PULSE_W)) begin : g_bad_extra
      $error("PULSE_EXTRA out of range");
   end

   logic sys_rst_n;
   assign sys_rst_n = rst_n & por_n;

   logic       bus_wr;
   logic [2:0] widx;
   assign bus_wr = wr_en & sys_rst_n;
   assign widx   = addr[4:2];

   logic wr_irq, wr_ctrl, wr_act, wr_match, wr_pin, wr_plen;
   assign wr_irq   = bus_wr && (widx == W_IRQ);
   assign wr_ctrl  = bus_wr && (widx == W_CTRL);
   assign wr_act   = bus_wr && (widx == W_ACT);
   assign wr_match = bus_wr && (widx == W_MATCH);
   assign wr_pin   = bus_wr && (widx == W_PIN);
   assign wr_plen  = bus_wr && (widx == W_PLEN);

   // control and action registers
   logic               ctrl_en, ctrl_dbg;
   logic               act_irq, act_stop, act_rsta, act_rstb;
   logic [CNT_W-1:0]   match_val;
   logic [PULSE_W-1:0] pulse_len;
   logic               irq_flag;
   logic               cause;

   logic               tick, clr, hit, stop_clr;
   logic [CNT_W-1:0]   cnt;

   assign tick     = ctrl_en && !(ctrl_dbg && dbg_halt);
   assign clr      = wr_ctrl && wdata[1];
   assign stop_clr = hit && act_stop;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         ctrl_en   <= 1'b0;
         ctrl_dbg  <= 1'b0;
         act_irq   <= 1'b0;
         act_stop  <= 1'b0;
         act_rsta  <= 1'b0;
         act_rstb  <= 1'b0;
         match_val <= '0;
         pulse_len <= '0;
         irq_flag  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_en  <= wdata[0];
            ctrl_dbg <= wdata[2];
         end else if (stop_clr) begin
            ctrl_en  <= 1'b0;
         end
         if (wr_act) begin
            act_irq  <= wdata[0];
            act_stop <= wdata[2];
            act_rsta <= wdata[3];
            act_rstb <= wdata[4];
         end
         if (wr_match) match_val <= wdata[CNT_W-1:0];
         if (wr_plen)  pulse_len <= wdata[PULSE_W-1:0];
         if (hit && act_irq)           irq_flag <= 1'b1;
         else if (wr_irq && wdata[0])  irq_flag <= 1'b0;
      end
   end

   assign irq = irq_flag;

   wdg_count_core #(.CNT_W(CNT_W)) i_core (
      .clk       (clk),
      .rst_n     (sys_rst_n),
      .tick      (tick),
      .clr       (clr),
      .stop_clr  (stop_clr),
      .match_val (match_val),
      .cnt       (cnt),
      .hit       (hit)
   );

   pin_act_e pin_act;

   wdg_pin_ctl i_pin (
      .clk    (clk),
      .rst_n  (sys_rst_n),
      .wr     (wr_pin),
      .wr_pin (wdata[0]),
      .wr_act (pin_act_e'(wdata[5:4])),
      .evt    (hit),
      .pin    (match_pin),
      .act    (pin_act)
   );

   // reset pulse generators, one per output, in the power-on domain
   logic [N_RST-1:0] rst_trig, rst_vec;
   assign rst_trig[0] = (hit && act_rsta) || (wr_act && wdata[5]);
   assign rst_trig[1] = (hit && act_rstb) || (wr_act && wdata[6]);

   for (genvar g = 0; g < N_RST; g++) begin : g_pulse
      wdg_rst_pulse #(.LEN_W(PULSE_W), .EXTRA(PULSE_EXTRA)) i_pulse (
         .clk    (clk),
         .por_n  (por_n),
         .trig   (rst_trig[g]),
         .len    (pulse_len),
         .active (rst_vec[g])
      );
   end

   assign rst_out_a = rst_vec[0];
   assign rst_out_b = rst_vec[1];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         cause <= 1'b0;
      else if (|rst_trig) cause <= 1'b1;
   end

   always_comb begin
      rdata = '0;
      case (widx)
         W_IRQ:   rdata[0]   = irq_flag;
         W_CTRL:  rdata[2:0] = {ctrl_dbg, 1'b0, ctrl_en};
         W_COUNT: rdata      = 32'(cnt);
         W_ACT:   rdata[4:0] = {act_rstb, act_rsta, act_stop, 1'b0, act_irq};
         W_MATCH: rdata      = 32'(match_val);
         W_PIN:   rdata[5:0] = {pin_act, 3'b000, match_pin};
         W_PLEN:  rdata      = 32'(pulse_len);
         default: rdata[0]   = cause;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{addr[1:0], wdata[31:7]};

   assert_irq_on_match_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (hit && act_irq) |=> irq);
   assert_stop_on_match_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (hit && act_stop && !wr_ctrl) |=> (!ctrl_en && cnt == '0));
   assert_force_a_R9: assert property (@(posedge clk) disable iff (!por_n)
      (wr_act && wdata[5]) |=> rst_out_a);
   assert_force_b_R9: assert property (@(posedge clk) disable iff (!por_n)
      (wr_act && wdata[6]) |=> rst_out_b);
   assert_cause_follows_pulse_R10: assert property (@(posedge clk) disable iff (!por_n)
      (rst_out_a || rst_out_b) |-> cause);
endmodule

// File: tb/test_wdg_match_timer.sv
module test_wdg_match_timer;
   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b0, dbg_halt = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, match_pin, rst_out_a, rst_out_b;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   wdg_match_timer i_wdg_match_timer (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .dbg_halt(dbg_halt),
      .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .irq(irq), .match_pin(match_pin), .rst_out_a(rst_out_a), .rst_out_b(rst_out_b)
   );

   localparam logic [4:0] A_IRQ = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08, A_ACT = 5'h0C,
                          A_MATCH = 5'h10, A_PIN = 5'h14, A_PLEN = 5'h18, A_CAUSE = 5'h1C;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h want 0x%08h", tag, act, exp);
      end
   endtask

   // called at a falling edge; the rising edge in between commits
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic run_to_stop(input logic [31:0] m);
      logic [31:0] v;
      wr(A_MATCH, m);
      wr(A_CTRL, 32'h3);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         rd(A_CTRL, v);
         if (v[0] == 1'b0) break;
      end
   endtask

   task automatic count_high(input bit which, output int n);
      n = 0;
      while ((which ? rst_out_b : rst_out_a) && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      for (int w = 0; w < 8; w++) begin
         rd(5'(w * 4), v);
         chk("R1 register zero after reset", v, 32'h0);
      end
      chk("R1 outputs low", {28'h0, irq, match_pin, rst_out_a, rst_out_b}, 32'h0);
   endtask

   task automatic t_count;
      logic [31:0] v;
      wr(A_CTRL, 32'h1);
      repeat (10) @(negedge clk);
      rd(A_CNT, v);  chk("R2 counts per clock", v, 32'd10);
      wr(A_CTRL, 32'h0);
      repeat (5) @(negedge clk);
      rd(A_CNT, v);  chk("R2 stop holds value", v, 32'd11);
      wr(A_CNT, 32'h1234);
      rd(A_CNT, v);  chk("R11 counter ignores writes", v, 32'd11);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      wr(A_CTRL, 32'h2);
      rd(A_CNT, v);  chk("R3 clear gives zero", v, 32'd0);
      rd(A_CTRL, v); chk("R3 clear bit reads 0", v, 32'd0);
      wr(A_CTRL, 32'h3);
      repeat (4) @(negedge clk);
      rd(A_CNT, v);  chk("R3 counting after clear", v, 32'd4);
      wr(A_CTRL, 32'h2);
      rd(A_CNT, v);  chk("R3 clear while running", v, 32'd0);
   endtask

   task automatic t_debug;
      logic [31:0] v;
      dbg_halt = 1'b1;
      wr(A_CTRL, 32'h7);
      repeat (5) @(negedge clk);
      rd(A_CNT, v);  chk("R4 halted by debug", v, 32'd0);
      dbg_halt = 1'b0;
      repeat (3) @(negedge clk);
      rd(A_CNT, v);  chk("R4 resumes after debug", v, 32'd3);
      wr(A_CTRL, 32'h3);
      dbg_halt = 1'b1;
      repeat (4) @(negedge clk);
      rd(A_CNT, v);  chk("R4 halt ignored without enable", v, 32'd4);
      dbg_halt = 1'b0;
      wr(A_CTRL, 32'h2);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      wr(A_MATCH, 32'd20);
      wr(A_ACT, 32'h1);
      wr(A_CTRL, 32'h3);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (irq) break;
      end
      rd(A_CNT, v);  chk("R5 irq edge after match", v, 32'd21);
      rd(A_IRQ, v);  chk("R5 flag set", v, 32'd1);
      wr(A_IRQ, 32'h0);
      rd(A_IRQ, v);  chk("R5 write 0 keeps flag", v, 32'd1);
      wr(A_IRQ, 32'h1);
      rd(A_IRQ, v);  chk("R5 write 1 clears flag", {v[31:1], v[0] | irq}, 32'd0);
      wr(A_CTRL, 32'h2);
   endtask

   task automatic t_stop;
      logic [31:0] v;
      wr(A_MATCH, 32'd15);
      wr(A_ACT, 32'h5);
      wr(A_CTRL, 32'h3);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (irq) break;
      end
      rd(A_CNT, v);  chk("R6 counter zero on match", v, 32'd0);
      rd(A_CTRL, v); chk("R6 enable cleared", v, 32'd0);
      repeat (5) @(negedge clk);
      rd(A_CNT, v);  chk("R6 stays stopped", v, 32'd0);
      wr(A_IRQ, 32'h1);
      wr(A_ACT, 32'h0);
   endtask

   task automatic t_pin;
      logic [31:0] v;
      wr(A_ACT, 32'h4);
      wr(A_PIN, 32'h20);
      run_to_stop(32'd8);
      rd(A_PIN, v);  chk("R7 code 2 drives high", v, 32'h21);
      chk("R7 pin port high", {31'h0, match_pin}, 32'h1);
      wr(A_PIN, 32'h31);
      run_to_stop(32'd6);
      rd(A_PIN, v);  chk("R7 code 3 inverts", v, 32'h30);
      wr(A_PIN, 32'h11);
      run_to_stop(32'd5);
      rd(A_PIN, v);  chk("R7 code 1 drives low", v, 32'h10);
      wr(A_PIN, 32'h01);
      run_to_stop(32'd4);
      rd(A_PIN, v);  chk("R7 code 0 keeps pin", v, 32'h01);
      wr(A_PIN, 32'h00);
   endtask

   task automatic t_match_rst;
      logic [31:0] v;
      int n;
      bit other;
      wr(A_PLEN, 32'd3);
      wr(A_ACT, 32'h0C);
      wr(A_MATCH, 32'd5);
      wr(A_CTRL, 32'h3);
      other = 1'b0;
      for (int i = 0; i < 50 && !rst_out_a; i++) begin
         @(negedge clk);
         other |= rst_out_b;
      end
      count_high(1'b0, n);
      chk("R8 pulse a length", 32'(n), 32'd9);
      chk("R8 output b quiet", {31'h0, other | rst_out_b}, 32'h0);
      rd(A_CAUSE, v); chk("R10 cause set by pulse", v, 32'd1);
      wr(A_ACT, 32'h14);
      wr(A_MATCH, 32'd7);
      wr(A_CTRL, 32'h3);
      other = 1'b0;
      for (int i = 0; i < 50 && !rst_out_b; i++) begin
         @(negedge clk);
         other |= rst_out_a;
      end
      count_high(1'b1, n);
      chk("R8 pulse b length", 32'(n), 32'd9);
      chk("R8 output a quiet", {31'h0, other | rst_out_a}, 32'h0);
      wr(A_ACT, 32'h0);
   endtask

   task automatic t_force;
      logic [31:0] v;
      int n;
      wr(A_PLEN, 32'd0);
      wr(A_ACT, 32'h20);
      chk("R9 force a immediate", {31'h0, rst_out_a}, 32'h1);
      rd(A_ACT, v);  chk("R9 force bit not stored", v, 32'h0);
      count_high(1'b0, n);
      chk("R9 forced a length", 32'(n), 32'd6);
      wr(A_ACT, 32'h40);
      chk("R9 force b immediate", {31'h0, rst_out_b}, 32'h1);
      count_high(1'b1, n);
      chk("R9 forced b length", 32'(n), 32'd6);
   endtask

   task automatic t_cause;
      logic [31:0] v;
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, v); chk("R10 cause ignores write", v, 32'd1);
      wr(A_CTRL, 32'h1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(A_CAUSE, v); chk("R10 cause survives system reset", v, 32'd1);
      rd(A_CTRL, v);  chk("R1 system reset clears control", v, 32'd0);
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      rd(A_CAUSE, v); chk("R10 power-on clears cause", v, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      por_n = 1'b1;
      rst_n = 1'b1;
      fork
         begin
            t_reset();
            t_count();
            t_clear();
            t_debug();
            t_irq();
            t_stop();
            t_pin();
            t_match_rst();
            t_force();
            t_cause();
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout want completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule